// File: doc/BRIEF.md
# Multi-Source Reset Generator with Cause Flags

This block merges three reasons for a system reset into one stretched, active-low reset output. The first is a supply-low indication from an analog comparator. The second is a one-cycle expiry request from a watchdog timer. The third is a push-button on the shared, bidirectional reset line. Each reason starts a reset pulse. The pulse is counted in strobes of a slow time-base tick, nominally one per 100 ms. It ends only after `STRETCH_TICKS` tick strobes have been seen with no new cause present. While the supply stays low, the output is held low. The count starts only once the supply has recovered.

The reset pad is modelled as a read-back input plus an output enable that pulls the line low. The line is synchronised and debounced before a low on it counts as a button press. While the block is itself pulling the line low, a low read back from the pad is not taken as a press. A press therefore never retriggers its own pulse.

The block keeps two sticky cause flags. The power flag records a supply-low event and the watchdog flag records a watchdog expiry. Only hardware sets them and only software clears them. A button press touches neither flag. When the output deasserts, a one-cycle release strobe is given, which can be used to restart the watchdog.

Top module: `reset_merge_ctrl`

## Requirements
- R1: While `arst_n` is low and after it rises, `rst_n_o` is low, `rst_oe_o` is high, `por_flag_o` is 1, `wdt_flag_o` is 0 and `release_o` is 0.
- R2: `supply_low_i` high, after `SYNC_STAGES` synchronising flops, holds `rst_n_o` low. Once the synchronised level falls, `rst_n_o` stays low until `STRETCH_TICKS` cycles with `tick_i` high have passed. It rises in the cycle after the last of those ticks.
- R3: A cycle with `wdt_req_i` high drives `rst_n_o` low from the next clock edge. If a pulse is already running, its tick count restarts. The request sets `wdt_flag_o` at that same edge.
- R4: When the synchronised pad input has been low for `DEB_CYCLES` consecutive cycles and the block is not driving the line, a pulse of the same length as in R2 starts. The press sets neither flag.
- R5: A low on `rst_pad_i` that lasts fewer than `DEB_CYCLES` consecutive synchronised samples has no effect on `rst_n_o`.
- R6: A pad low that is seen while `rst_oe_o` is high does not start a new pulse or extend the current one.
- R7: Each flag stays set until its clear input (`clr_por_i` for the power flag, `clr_wdt_i` for the watchdog flag) is high at a clock edge. A set event in the same cycle wins over the clear. Both flags can be 1 at the same time.
- R8: `release_o` is high for exactly one cycle, in the cycle in which `rst_n_o` first reads high after a pulse. It is low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| tick_i | input | 1 | One-cycle time-base strobe, nominally every 100 ms |
| supply_low_i | input | 1 | Asynchronous supply-below-threshold level |
| wdt_req_i | input | 1 | One-cycle watchdog expiry request |
| rst_pad_i | input | 1 | Read-back level of the reset pad (low = asserted) |
| clr_por_i | input | 1 | Software clear of the power flag |
| clr_wdt_i | input | 1 | Software clear of the watchdog flag |
| rst_n_o | output | 1 | Stretched reset output, active low |
| rst_oe_o | output | 1 | Pad pull-low enable |
| por_flag_o | output | 1 | Sticky supply-low cause flag |
| wdt_flag_o | output | 1 | Sticky watchdog cause flag |
| release_o | output | 1 | One-cycle strobe when reset deasserts |

## Verification
The pulse logic is tried with a long supply-low level, a single watchdog request, and a sustained button press. Together these show that the stretch starts counting only after the hold ends, and that only the supply and watchdog causes touch the flags. A press that is too short separates a working debouncer from one that is missing or too short. A press placed inside a watchdog pulse shows whether the block ignores its own drive, because a faulty block would produce a second release strobe. Clears are issued alone and together with a set, to check set priority and that both flags can be set at once.

// File: rtl/reset_merge_pkg.sv
package reset_merge_pkg;

  // Counter width able to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Remaining ticks after one tick strobe; 0 means the pulse ends
  function automatic int unsigned ticks_after(input int unsigned remain);
    return (remain == 0) ? 0 : remain - 1;
  endfunction

  typedef struct packed {
    logic wdt;
    logic por;
  } cause_t;

endpackage

// File: rtl/rmg_sync.sv
module rmg_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n)
          if (!arst_n) chain[0] <= RESET_VAL;
          else         chain[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n)
          if (!arst_n) chain[g] <= RESET_VAL;
          else         chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rmg_debounce.sv
module rmg_debounce #(
  parameter int unsigned DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic sample_i,
  output logic filt_o,
  output logic press_o
);
  import reset_merge_pkg::*;
  localparam int unsigned CW = cnt_width(DEB_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          differ;
  logic          settle;

  assign differ = (sample_i != filt_o);
  assign settle = differ && (cnt == LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      filt_o  <= 1'b1;
      cnt     <= '0;
      press_o <= 1'b0;
    end else begin
      press_o <= settle && !sample_i;
      if (!differ || settle) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
      if (settle) filt_o <= sample_i;
    end
  end

  AST_PRESS_IS_LOW: assert property (@(posedge clk) disable iff (!arst_n)
    press_o |-> !filt_o);  // R4
  AST_DEB_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    cnt <= LAST);  // R5
endmodule

// File: rtl/rmg_stretch.sv
module rmg_stretch #(
  parameter int unsigned STRETCH_TICKS = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold_i,
  input  logic trig_i,
  input  logic tick_i,
  output logic active_o,
  output logic release_o
);
  import reset_merge_pkg::*;
  localparam int unsigned    W    = cnt_width(STRETCH_TICKS);
  localparam logic [W-1:0]   LOAD = W'(STRETCH_TICKS);

  logic [W-1:0] remain;
  logic         load;
  logic         expire;

  assign load   = hold_i || trig_i;
  assign expire = active_o && tick_i && (ticks_after(int'(remain)) == 0);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      active_o  <= 1'b1;
      remain    <= LOAD;
      release_o <= 1'b0;
    end else begin
      release_o <= 1'b0;
      if (load) begin
        active_o <= 1'b1;
        remain   <= LOAD;
      end else if (expire) begin
        active_o  <= 1'b0;
        release_o <= 1'b1;
      end else if (active_o && tick_i) begin
        remain <= W'(ticks_after(int'(remain)));
      end
    end
  end

  AST_HOLD_DRIVES: assert property (@(posedge clk) disable iff (!arst_n)
    hold_i |=> active_o);  // R2
  AST_REMAIN_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
    (remain != 0) && (remain <= LOAD));  // R2
  AST_TRIG_DRIVES: assert property (@(posedge clk) disable iff (!arst_n)
    trig_i |=> active_o);  // R3
  AST_RELEASE_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    release_o |=> !release_o);  // R8
  AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!arst_n)
    release_o |-> (!active_o && $past(active_o)));  // R8
endmodule

// File: rtl/reset_merge_ctrl.sv
module reset_merge_ctrl #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned DEB_CYCLES    = 4,
  parameter int unsigned STRETCH_TICKS = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_i,
  input  logic supply_low_i,
  input  logic wdt_req_i,
  input  logic rst_pad_i,
  input  logic clr_por_i,
  input  logic clr_wdt_i,
  output logic rst_n_o,
  output logic rst_oe_o,
  output logic por_flag_o,
  output logic wdt_flag_o,
  output logic release_o
);
  import reset_merge_pkg::*;

  logic   supply_low_s;
  logic   pad_s;
  logic   pad_filt;
  logic   press;
  logic   active;
  logic   manual_trig;
  logic   any_trig;
  cause_t cause;

  rmg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sup (
    .clk(clk), .arst_n(arst_n), .d_i(supply_low_i), .q_o(supply_low_s));

  rmg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_pad (
    .clk(clk), .arst_n(arst_n), .d_i(rst_pad_i), .q_o(pad_s));

  rmg_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk(clk), .arst_n(arst_n), .sample_i(pad_s),
    .filt_o(pad_filt), .press_o(press));

  // A press seen while the block drives the pad is its own echo
  assign manual_trig = press && !active;
  assign any_trig    = wdt_req_i || manual_trig;

  rmg_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_str (
    .clk(clk), .arst_n(arst_n), .hold_i(supply_low_s), .trig_i(any_trig),
    .tick_i(tick_i), .active_o(active), .release_o(release_o));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cause.por <= 1'b1;
      cause.wdt <= 1'b0;
    end else begin
      if (supply_low_s)   cause.por <= 1'b1;
      else if (clr_por_i) cause.por <= 1'b0;
      if (wdt_req_i)      cause.wdt <= 1'b1;
      else if (clr_wdt_i) cause.wdt <= 1'b0;
    end
  end

  assign rst_oe_o   = active;
  assign rst_n_o    = !active;
  assign por_flag_o = cause.por;
  assign wdt_flag_o = cause.wdt;

  AST_POR_SET: assert property (@(posedge clk) disable iff (!arst_n)
    supply_low_s |=> por_flag_o);  // R2
  AST_WDT_SET: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_req_i |=> wdt_flag_o);  // R3
  AST_POR_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
    (por_flag_o && !clr_por_i) |=> por_flag_o);  // R7
  AST_WDT_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
    (wdt_flag_o && !clr_wdt_i) |=> wdt_flag_o);  // R7
  AST_NO_SELF_TRIG: assert property (@(posedge clk) disable iff (!arst_n)
    (press && active && !wdt_req_i && !supply_low_s && !wdt_flag_o) |=> !wdt_flag_o);  // R6
endmodule

// File: tb/sim_reset_merge_ctrl.sv
module sim_reset_merge_ctrl;
  localparam int SYNC = 2;
  localparam int DEB  = 4;
  localparam int STR  = 3;
  localparam int TGAP = 10;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic tick_i = 1'b0;
  logic supply_low_i = 1'b0;
  logic wdt_req_i = 1'b0;
  logic ext_n = 1'b1;
  logic clr_por_i = 1'b0;
  logic clr_wdt_i = 1'b0;
  logic rst_pad_i;
  logic rst_n_o, rst_oe_o, por_flag_o, wdt_flag_o, release_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tcnt   = 0;
  int rel_seen = 0;

  always #2.5 clk = ~clk;

  assign rst_pad_i = ext_n & ~rst_oe_o;

  reset_merge_ctrl #(.SYNC_STAGES(SYNC), .DEB_CYCLES(DEB), .STRETCH_TICKS(STR)) u0 (
    .clk(clk), .arst_n(arst_n), .tick_i(tick_i), .supply_low_i(supply_low_i),
    .wdt_req_i(wdt_req_i), .rst_pad_i(rst_pad_i), .clr_por_i(clr_por_i),
    .clr_wdt_i(clr_wdt_i), .rst_n_o(rst_n_o), .rst_oe_o(rst_oe_o),
    .por_flag_o(por_flag_o), .wdt_flag_o(wdt_flag_o), .release_o(release_o));

  // Free-running time base
  always @(negedge clk) begin
    tcnt   <= (tcnt == TGAP - 1) ? 0 : tcnt + 1;
    tick_i <= (tcnt == TGAP - 1);
  end

  // Behavioural reference model
  bit m_sup[$];
  bit m_pad[$];
  bit m_filt, m_press, m_active, m_por, m_wdt, m_rel;
  int m_cnt, m_remain;

  always @(posedge clk or negedge arst_n) begin
    bit sup_seen, pad_seen, trig, new_press;
    if (!arst_n) begin
      m_sup.delete(); m_pad.delete();
      for (int i = 0; i < SYNC; i++) begin m_sup.push_back(1'b0); m_pad.push_back(1'b1); end
      m_filt = 1; m_cnt = 0; m_press = 0; m_active = 1; m_remain = STR;
      m_por = 1; m_wdt = 0; m_rel = 0;
    end else begin
      sup_seen = m_sup[0];
      pad_seen = m_pad[0];
      void'(m_sup.pop_front()); m_sup.push_back(supply_low_i);
      void'(m_pad.pop_front()); m_pad.push_back(ext_n & !m_active);
      trig = wdt_req_i || (m_press && !m_active);
      new_press = 0;
      if (pad_seen == m_filt) m_cnt = 0;
      else if (m_cnt == DEB - 1) begin
        m_filt = pad_seen; m_cnt = 0; new_press = !pad_seen;
      end else m_cnt++;
      m_rel = 0;
      if (sup_seen || trig) begin m_active = 1; m_remain = STR; end
      else if (m_active && tick_i) begin
        if (m_remain == 1) begin m_active = 0; m_rel = 1; end
        else m_remain--;
      end
      if (sup_seen) m_por = 1; else if (clr_por_i) m_por = 0;
      if (wdt_req_i) m_wdt = 1; else if (clr_wdt_i) m_wdt = 0;
      m_press = new_press;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (release_o === 1'b1) rel_seen++;
    if (arst_n) begin
      check("R2 rst_n_o vs model", rst_n_o, !m_active);
      check("R7 por_flag_o vs model", por_flag_o, m_por);
      check("R7 wdt_flag_o vs model", wdt_flag_o, m_wdt);
      check("R8 release_o vs model", release_o, m_rel);
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int r0;
    wait_n(3);
    check("R1 rst_n_o in reset", rst_n_o, 1'b0);
    check("R1 rst_oe_o in reset", rst_oe_o, 1'b1);
    check("R1 por flag in reset", por_flag_o, 1'b1);
    check("R1 wdt flag in reset", wdt_flag_o, 1'b0);
    check("R1 release_o in reset", release_o, 1'b0);
    arst_n = 1'b1;
    wait_n(1);
    check("R1 rst_n_o after reset", rst_n_o, 1'b0);
    wait_n(40);
    check("R2 pulse ended after ticks", rst_n_o, 1'b1);
    clr_por_i = 1; wait_n(1); clr_por_i = 0;
    check("R7 por cleared", por_flag_o, 1'b0);

    // Supply low hold then stretch
    supply_low_i = 1; wait_n(30);
    check("R2 held low", rst_n_o, 1'b0);
    check("R2 por set", por_flag_o, 1'b1);
    supply_low_i = 0; wait_n(6);
    check("R2 still stretched", rst_n_o, 1'b0);
    wait_n(40);
    check("R2 released", rst_n_o, 1'b1);

    // Watchdog request
    wdt_req_i = 1; wait_n(1); wdt_req_i = 0;
    check("R3 asserted next edge", rst_n_o, 1'b0);
    check("R3 wdt flag set", wdt_flag_o, 1'b1);
    check("R7 both flags set", por_flag_o & wdt_flag_o, 1'b1);
    wait_n(40);
    // Clear both while a new request arrives: set wins for wdt
    clr_por_i = 1; clr_wdt_i = 1; wdt_req_i = 1; wait_n(1);
    clr_por_i = 0; clr_wdt_i = 0; wdt_req_i = 0;
    check("R7 set beats clear", wdt_flag_o, 1'b1);
    check("R7 por cleared", por_flag_o, 1'b0);
    wait_n(40);
    clr_wdt_i = 1; wait_n(1); clr_wdt_i = 0;
    check("R7 wdt cleared", wdt_flag_o, 1'b0);

    // Manual press
    ext_n = 0; wait_n(12); ext_n = 1;
    check("R4 manual pulse", rst_n_o, 1'b0);
    check("R4 no por flag", por_flag_o, 1'b0);
    check("R4 no wdt flag", wdt_flag_o, 1'b0);
    wait_n(40);
    check("R4 manual released", rst_n_o, 1'b1);

    // Glitch shorter than debounce
    ext_n = 0; wait_n(DEB - 1); ext_n = 1;
    wait_n(20);
    check("R5 glitch ignored", rst_n_o, 1'b1);

    // Press during own drive
    wait_n(5);
    wdt_req_i = 1; wait_n(1); wdt_req_i = 0;
    r0 = rel_seen;
    wait_n(3);
    ext_n = 0; wait_n(8); ext_n = 1;
    wait_n(60);
    check("R6 single release strobe", (rel_seen - r0) == 1, 1'b1);
    check("R6 line released", rst_n_o, 1'b1);
    check("R8 release low at rest", release_o, 1'b0);

    wait_n(5);
    finish_run();
  end
endmodule